// File: doc/BRIEF.md
# Debug Authentication Session Controller

This block runs the challenge-response exchange that unlocks a debug port on a device in the manufacturing or return-to-service lifecycle state. A rising edge on the test reset line opens a session. The block then captures the device's 96-bit unique identifier and a fresh 128-bit nonce, and presents both to the debugger. The upper part of the nonce is the boot counter, so a signed reply from an earlier power cycle can never match. After the debugger submits the capabilities it wants, the block assembles the message to be signed and hands it to an external signature verifier. It then waits for that verifier's verdict.

A passing verdict sets the authentication flag, which holds until the next reset. It also latches the effective capability mask, which is the bitwise AND of the requested mask and the mask the verifier grants. A failing verdict advances a saturating failure count. The failure that brings this count to the threshold raises a single tamper event and starts a refusal window. That window is timed by real-time-clock ticks, and no new session can begin while it runs. In the return-to-service state, a passing verdict counts only once the key-wipe flag is set.

Top module: `dbg_auth_session`

## Requirements
- R1: A session opens only when `lc_state` equals exactly the manufacturing code 8'h04 (bit 2 alone) or the return-to-service code 8'h10 (bit 4 alone). In any other state, a rising edge on `trst` leaves `chal_valid` low.
- R2: A rising edge on `trst` in an idle, eligible, unlocked state raises `chal_valid` after one clock edge, with `chal_uid` equal to the `dev_uid` value sampled at that edge.
- R3: `chal_nonce` equals {`boot_count`, `rnd_in`} (boot counter in bits 127:96) as sampled at the opening edge. It stays unchanged while the session runs, even if those inputs change.
- R4: One edge after `req_valid` in an open session, `ver_req` goes high and `ver_msg` holds, from MSB to LSB: the 56-bit tag `MSG_TAG`, the identifier, the nonce, and the latched requested capabilities.
- R5: After a passing verdict, `auth_valid` stays high until reset, and further `trst` edges open no new session.
- R6: On a pass, `eff_caps` becomes `ver_grant` AND the latched requested mask, and it stays constant while `auth_valid` is high.
- R7: In the return-to-service state, a passing verdict with `wipe_done` low leaves `auth_valid` low and counts as a failure.
- R8: Each failing verdict raises `fail_cnt` (8 bits) by one, saturating at 255.
- R9: The failure that takes `fail_cnt` from 15 to 16 makes `tamper_evt` high for exactly one cycle and raises `lockout` in the same cycle. While `lockout` is high, `trst` edges open no session.
- R10: `lockout` falls after `LOCK_TICKS` `rtc_tick` pulses. After that, sessions open again, `fail_cnt` keeps its value, and later failures raise no further tamper event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; ends any authentication |
| lc_state | input | 8 | One-hot lifecycle state |
| wipe_done | input | 1 | Key wipe finished (return-to-service) |
| dev_uid | input | 96 | Device unique identifier |
| boot_count | input | 32 | Boot counter folded into the nonce |
| rnd_in | input | 96 | Random source for the nonce |
| trst | input | 1 | Test reset from the debugger; rising edge opens a session |
| req_valid | input | 1 | Requested capabilities present |
| req_caps | input | 8 | Requested capability mask |
| ver_done | input | 1 | Verifier verdict available |
| ver_pass | input | 1 | Verifier verdict: signature good |
| ver_grant | input | 8 | Capabilities granted by the verifier |
| rtc_tick | input | 1 | Real-time-clock tick for the lockout timer |
| chal_valid | output | 1 | Session open, challenge registers valid |
| chal_uid | output | 96 | Identifier shown to the debugger |
| chal_nonce | output | 128 | Nonce shown to the debugger |
| ver_req | output | 1 | Verification request |
| ver_msg | output | 288 | Message to be verified |
| auth_valid | output | 1 | Debug authenticated for this boot |
| eff_caps | output | 8 | Effective capability mask |
| fail_cnt | output | 8 | Saturating failure count |
| tamper_evt | output | 1 | One-cycle tamper log event |
| lockout | output | 1 | Refusal window active |

## Verification
Runs of verdicts are driven in several mixes: a lone failure followed by a pass, a pass in the return-to-service state with the wipe flag both low and high, sixteen back-to-back failures, and a long failure run past saturation. These mixes separate the failure path, the wipe gate, the threshold event and plain saturation. Capability masks are chosen so that requested, granted and their AND all differ, which exposes a mask that is copied rather than combined. Opening edges are also tried in locked, development and blank states, in an already-authenticated session, and during lockout, to show that each one is refused.

// File: rtl/dbg_auth_pkg.sv
package dbg_auth_pkg;

    localparam int LC_W       = 8;
    localparam int TAG_W      = 56;
    localparam int LC_MFG_BIT = 2;
    localparam int LC_RMA_BIT = 4;

    localparam logic [LC_W-1:0] LC_MFG = LC_W'(1) << LC_MFG_BIT;
    localparam logic [LC_W-1:0] LC_RMA = LC_W'(1) << LC_RMA_BIT;

    typedef enum logic [1:0] {
        SS_IDLE   = 2'd0,
        SS_CHAL   = 2'd1,
        SS_VERIFY = 2'd2
    } sess_st_e;

endpackage

// File: rtl/dbg_auth_chal.sv
module dbg_auth_chal #(
    parameter int UID_W   = 96,
    parameter int NONCE_W = 128,
    parameter int BOOT_W  = 32,
    localparam int RND_W  = NONCE_W - BOOT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [UID_W-1:0]   uid_in,
    input  logic [BOOT_W-1:0]  boot_in,
    input  logic [RND_W-1:0]   rnd_in,
    output logic [UID_W-1:0]   uid_q,
    output logic [NONCE_W-1:0] nonce_q
);

    typedef struct packed {
        logic [UID_W-1:0]   uid;
        logic [NONCE_W-1:0] nonce;
    } chal_t;

    chal_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.uid   = uid_in;
            r_d.nonce = {boot_in, rnd_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign uid_q   = r_q.uid;
    assign nonce_q = r_q.nonce;

endmodule

// File: rtl/dbg_auth_guard.sv
module dbg_auth_guard #(
    parameter int FAIL_W     = 8,
    parameter int TAMPER_AT  = 16,
    parameter int LOCK_TICKS = 86400,
    localparam int LOCK_W    = $clog2(LOCK_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fail_evt,
    input  logic              rtc_tick,
    output logic [FAIL_W-1:0] fail_cnt,
    output logic              tamper_evt,
    output logic              lockout
);

    localparam logic [FAIL_W-1:0] TRIP_PREV = FAIL_W'(TAMPER_AT - 1);
    localparam logic [LOCK_W-1:0] LOCK_LOAD = LOCK_W'(LOCK_TICKS);

    typedef struct packed {
        logic [FAIL_W-1:0] cnt;
        logic [LOCK_W-1:0] lock;
        logic              tamper;
    } guard_t;

    guard_t g_d, g_q;

    always_comb begin
        g_d        = g_q;
        g_d.tamper = 1'b0;
        if (rtc_tick && (g_q.lock != '0))
            g_d.lock = g_q.lock - 1'b1;
        if (fail_evt) begin
            if (g_q.cnt != '1)
                g_d.cnt = g_q.cnt + 1'b1;
            if (g_q.cnt == TRIP_PREV) begin
                g_d.tamper = 1'b1;
                g_d.lock   = LOCK_LOAD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign fail_cnt   = g_q.cnt;
    assign tamper_evt = g_q.tamper;
    assign lockout    = (g_q.lock != '0);

endmodule

// File: rtl/dbg_auth_session.sv
module dbg_auth_session
    import dbg_auth_pkg::*;
#(
    parameter int                UID_W      = 96,
    parameter int                NONCE_W    = 128,
    parameter int                BOOT_W     = 32,
    parameter int                CAP_W      = 8,
    parameter int                FAIL_W     = 8,
    parameter int                TAMPER_AT  = 16,
    parameter int                LOCK_TICKS = 86400,
    parameter logic [TAG_W-1:0]  MSG_TAG    = 56'h44424741555448,
    localparam int               RND_W      = NONCE_W - BOOT_W,
    localparam int               MSG_W      = TAG_W + UID_W + NONCE_W + CAP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LC_W-1:0]    lc_state,
    input  logic               wipe_done,
    input  logic [UID_W-1:0]   dev_uid,
    input  logic [BOOT_W-1:0]  boot_count,
    input  logic [RND_W-1:0]   rnd_in,
    input  logic               trst,
    input  logic               req_valid,
    input  logic [CAP_W-1:0]   req_caps,
    input  logic               ver_done,
    input  logic               ver_pass,
    input  logic [CAP_W-1:0]   ver_grant,
    input  logic               rtc_tick,
    output logic               chal_valid,
    output logic [UID_W-1:0]   chal_uid,
    output logic [NONCE_W-1:0] chal_nonce,
    output logic               ver_req,
    output logic [MSG_W-1:0]   ver_msg,
    output logic               auth_valid,
    output logic [CAP_W-1:0]   eff_caps,
    output logic [FAIL_W-1:0]  fail_cnt,
    output logic               tamper_evt,
    output logic               lockout
);

    typedef struct packed {
        sess_st_e         st;
        logic             trst;
        logic [CAP_W-1:0] req;
        logic             auth;
        logic [CAP_W-1:0] eff;
    } ctl_t;

    ctl_t c_d, c_q;
    logic start, fail_evt, trst_rise, gate_ok, wipe_ok;

    always_comb begin
        c_d       = c_q;
        c_d.trst  = trst;
        start     = 1'b0;
        fail_evt  = 1'b0;
        trst_rise = trst & ~c_q.trst;
        gate_ok   = (lc_state == LC_MFG) || (lc_state == LC_RMA);
        wipe_ok   = (lc_state != LC_RMA) || wipe_done;
        unique case (c_q.st)
            SS_IDLE: begin
                if (trst_rise && gate_ok && !c_q.auth && !lockout) begin
                    start    = 1'b1;
                    c_d.st   = SS_CHAL;
                end
            end
            SS_CHAL: begin
                if (req_valid) begin
                    c_d.req = req_caps;
                    c_d.st  = SS_VERIFY;
                end
            end
            SS_VERIFY: begin
                if (ver_done) begin
                    c_d.st = SS_IDLE;
                    if (ver_pass && gate_ok && wipe_ok) begin
                        c_d.auth = 1'b1;
                        c_d.eff  = ver_grant & c_q.req;
                    end else begin
                        fail_evt = 1'b1;
                    end
                end
            end
            default: c_d.st = SS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: SS_IDLE, default: '0};
        else        c_q <= c_d;
    end

    dbg_auth_chal #(
        .UID_W   (UID_W),
        .NONCE_W (NONCE_W),
        .BOOT_W  (BOOT_W)
    ) u_chal (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .uid_in  (dev_uid),
        .boot_in (boot_count),
        .rnd_in  (rnd_in),
        .uid_q   (chal_uid),
        .nonce_q (chal_nonce)
    );

    dbg_auth_guard #(
        .FAIL_W     (FAIL_W),
        .TAMPER_AT  (TAMPER_AT),
        .LOCK_TICKS (LOCK_TICKS)
    ) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .fail_evt   (fail_evt),
        .rtc_tick   (rtc_tick),
        .fail_cnt   (fail_cnt),
        .tamper_evt (tamper_evt),
        .lockout    (lockout)
    );

    assign chal_valid = (c_q.st != SS_IDLE);
    assign ver_req    = (c_q.st == SS_VERIFY);
    assign ver_msg    = {MSG_TAG, chal_uid, chal_nonce, c_q.req};
    assign auth_valid = c_q.auth;
    assign eff_caps   = c_q.eff;

endmodule

// File: rtl/dbg_auth_session_chk.sv
module dbg_auth_session_chk
    import dbg_auth_pkg::*;
#(
    parameter int CAP_W  = 8,
    parameter int FAIL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LC_W-1:0]   lc_state,
    input logic              wipe_done,
    input logic              chal_valid,
    input logic              ver_req,
    input logic [CAP_W-1:0]  ver_grant,
    input logic              auth_valid,
    input logic [CAP_W-1:0]  eff_caps,
    input logic [FAIL_W-1:0] fail_cnt,
    input logic              tamper_evt,
    input logic              lockout
);

    AST_OPEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chal_valid) |-> ($past(lc_state) == LC_MFG || $past(lc_state) == LC_RMA)); // R1

    AST_AUTH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        auth_valid |=> auth_valid); // R5

    AST_CAPS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        auth_valid |=> $stable(eff_caps)); // R6

    AST_CAPS_WITHIN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(auth_valid) |-> ((eff_caps & ~$past(ver_grant)) == '0)); // R6

    AST_RMA_NEEDS_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(auth_valid) && $past(lc_state) == LC_RMA) |-> $past(wipe_done)); // R7

    AST_FAIL_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_cnt == '1) |=> (fail_cnt == '1)); // R8

    AST_FAIL_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fail_cnt >= $past(fail_cnt))); // R8

    AST_TAMPER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tamper_evt |=> !tamper_evt); // R9

    AST_TAMPER_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        tamper_evt |-> lockout); // R9

    AST_LOCK_NO_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> !ver_req); // R9

endmodule

bind dbg_auth_session dbg_auth_session_chk #(
    .CAP_W  (CAP_W),
    .FAIL_W (FAIL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lc_state   (lc_state),
    .wipe_done  (wipe_done),
    .chal_valid (chal_valid),
    .ver_req    (ver_req),
    .ver_grant  (ver_grant),
    .auth_valid (auth_valid),
    .eff_caps   (eff_caps),
    .fail_cnt   (fail_cnt),
    .tamper_evt (tamper_evt),
    .lockout    (lockout)
);

// File: tb/dbg_auth_session_tb.sv
module dbg_auth_session_tb;

    localparam int LOCKT = 5;
    localparam logic [55:0] TAG = 56'h44424741555448;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   lc_state = 8'h00;
    logic         wipe_done = 1'b0;
    logic [95:0]  dev_uid = '0;
    logic [31:0]  boot_count = '0;
    logic [95:0]  rnd_in = '0;
    logic         trst = 1'b0;
    logic         req_valid = 1'b0;
    logic [7:0]   req_caps = '0;
    logic         ver_done = 1'b0;
    logic         ver_pass = 1'b0;
    logic [7:0]   ver_grant = '0;
    logic         rtc_tick = 1'b0;
    logic         chal_valid, ver_req, auth_valid, tamper_evt, lockout;
    logic [95:0]  chal_uid;
    logic [127:0] chal_nonce;
    logic [287:0] ver_msg;
    logic [7:0]   eff_caps, fail_cnt;

    always #5 clk = ~clk;

    dbg_auth_session #(.LOCK_TICKS(LOCKT)) u_dut (
        .clk(clk), .rst_n(rst_n), .lc_state(lc_state), .wipe_done(wipe_done),
        .dev_uid(dev_uid), .boot_count(boot_count), .rnd_in(rnd_in), .trst(trst),
        .req_valid(req_valid), .req_caps(req_caps), .ver_done(ver_done),
        .ver_pass(ver_pass), .ver_grant(ver_grant), .rtc_tick(rtc_tick),
        .chal_valid(chal_valid), .chal_uid(chal_uid), .chal_nonce(chal_nonce),
        .ver_req(ver_req), .ver_msg(ver_msg), .auth_valid(auth_valid),
        .eff_caps(eff_caps), .fail_cnt(fail_cnt), .tamper_evt(tamper_evt),
        .lockout(lockout)
    );

    typedef struct packed {
        logic       cv;
        logic       vr;
        logic       av;
        logic [7:0] ec;
        logic [7:0] fc;
        logic       lo;
        logic       te;
    } snap_t;

    typedef struct {
        string rq;
        snap_t exp;
    } item_t;

    item_t sb_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    task automatic expect_snap(input string rq, input logic cv, input logic vr,
                               input logic av, input logic [7:0] ec,
                               input logic [7:0] fc, input logic lo, input logic te);
        item_t it;
        it.rq  = rq;
        it.exp = '{cv: cv, vr: vr, av: av, ec: ec, fc: fc, lo: lo, te: te};
        sb_q.push_back(it);
    endtask

    initial begin
        forever begin
            item_t it;
            snap_t act;
            wait (sb_q.size() != 0);
            it  = sb_q.pop_front();
            act = '{cv: chal_valid, vr: ver_req, av: auth_valid, ec: eff_caps,
                    fc: fail_cnt, lo: lockout, te: tamper_evt};
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s status actual=%h expected=%h", it.rq, act, it.exp);
            end
        end
    end

    task automatic chk_vec(input string rq, input logic [287:0] act, input logic [287:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_trst();
        trst = 1'b1;
        @(negedge clk);
        trst = 1'b0;
        @(negedge clk);
    endtask

    task automatic attempt(input logic [7:0] caps, input logic pass, input logic [7:0] grant);
        trst = 1'b1;
        @(negedge clk);
        trst      = 1'b0;
        req_valid = 1'b1;
        req_caps  = caps;
        @(negedge clk);
        req_valid = 1'b0;
        ver_done  = 1'b1;
        ver_pass  = pass;
        ver_grant = grant;
        @(negedge clk);
        ver_done  = 1'b0;
        ver_pass  = 1'b0;
    endtask

    task automatic tick();
        rtc_tick = 1'b1;
        @(negedge clk);
        rtc_tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        expect_snap("reset", 0, 0, 0, 8'h00, 8'h00, 0, 0);

        // R1: ineligible lifecycle states refuse the opening edge
        lc_state = 8'h08;
        trst = 1'b1; @(negedge clk);
        expect_snap("R1 locked", 0, 0, 0, 8'h00, 8'h00, 0, 0);
        trst = 1'b0; @(negedge clk);
        lc_state = 8'h02;
        trst = 1'b1; @(negedge clk);
        expect_snap("R1 dev", 0, 0, 0, 8'h00, 8'h00, 0, 0);
        trst = 1'b0; @(negedge clk);
        lc_state = 8'h14;
        trst = 1'b1; @(negedge clk);
        expect_snap("R1 malformed", 0, 0, 0, 8'h00, 8'h00, 0, 0);
        trst = 1'b0; @(negedge clk);

        // R2 / R3: challenge capture in manufacturing state
        lc_state   = 8'h04;
        dev_uid    = 96'h0123_4567_89AB_CDEF_1122_3344;
        boot_count = 32'h0000_0007;
        rnd_in     = 96'hDEAD_BEEF_CAFE_F00D_5A5A_A5A5;
        trst = 1'b1; @(negedge clk);
        expect_snap("R2 open", 1, 0, 0, 8'h00, 8'h00, 0, 0);
        chk_vec("R2 uid", 288'(chal_uid), 288'(96'h0123_4567_89AB_CDEF_1122_3344));
        chk_vec("R3 nonce", 288'(chal_nonce),
                288'({32'h0000_0007, 96'hDEAD_BEEF_CAFE_F00D_5A5A_A5A5}));
        trst = 1'b0;
        boot_count = 32'h0000_0008;
        rnd_in     = 96'h1;
        dev_uid    = 96'h2;
        @(negedge clk);
        chk_vec("R3 nonce held", 288'(chal_nonce),
                288'({32'h0000_0007, 96'hDEAD_BEEF_CAFE_F00D_5A5A_A5A5}));

        // R4: message layout
        req_valid = 1'b1; req_caps = 8'hF3; @(negedge clk);
        req_valid = 1'b0;
        expect_snap("R4 request", 1, 1, 0, 8'h00, 8'h00, 0, 0);
        chk_vec("R4 msg", ver_msg, {TAG, 96'h0123_4567_89AB_CDEF_1122_3344,
                32'h0000_0007, 96'hDEAD_BEEF_CAFE_F00D_5A5A_A5A5, 8'hF3});

        // R8: one failure
        ver_done = 1'b1; ver_pass = 1'b0; @(negedge clk);
        ver_done = 1'b0;
        expect_snap("R8 first fail", 0, 0, 0, 8'h00, 8'h01, 0, 0);

        // R6: pass with distinct masks
        attempt(8'h3C, 1'b1, 8'hA5);
        expect_snap("R6 pass caps", 0, 0, 1, 8'h24, 8'h01, 0, 0);

        // R5: sticky, no new session
        trst = 1'b1; @(negedge clk);
        expect_snap("R5 no reopen", 0, 0, 1, 8'h24, 8'h01, 0, 0);
        trst = 1'b0; @(negedge clk);
        do_reset();
        expect_snap("R5 cleared by reset", 0, 0, 0, 8'h00, 8'h00, 0, 0);

        // R7: return-to-service needs wipe
        lc_state = 8'h10; wipe_done = 1'b0;
        attempt(8'hFF, 1'b1, 8'h0F);
        expect_snap("R7 no wipe", 0, 0, 0, 8'h00, 8'h01, 0, 0);
        @(negedge clk);
        wipe_done = 1'b1;
        attempt(8'hFF, 1'b1, 8'h0F);
        expect_snap("R7 wiped", 0, 0, 1, 8'h0F, 8'h01, 0, 0);

        // R9: threshold at 16 failures
        do_reset();
        lc_state = 8'h04;
        for (int i = 0; i < 15; i++) begin
            attempt(8'h01, 1'b0, 8'h00);
            @(negedge clk);
        end
        expect_snap("R9 before trip", 0, 0, 0, 8'h00, 8'd15, 0, 0);
        attempt(8'h01, 1'b0, 8'h00);
        expect_snap("R9 trip", 0, 0, 0, 8'h00, 8'd16, 1, 1);
        @(negedge clk);
        expect_snap("R9 single pulse", 0, 0, 0, 8'h00, 8'd16, 1, 0);
        trst = 1'b1; @(negedge clk);
        expect_snap("R9 refused in lockout", 0, 0, 0, 8'h00, 8'd16, 1, 0);
        trst = 1'b0; @(negedge clk);

        // R10: lockout window in ticks
        for (int i = 0; i < LOCKT - 1; i++) begin
            tick();
            @(negedge clk);
        end
        expect_snap("R10 still locked", 0, 0, 0, 8'h00, 8'd16, 1, 0);
        tick();
        expect_snap("R10 unlocked", 0, 0, 0, 8'h00, 8'd16, 0, 0);
        attempt(8'h01, 1'b0, 8'h00);
        expect_snap("R10 accepted again", 0, 0, 0, 8'h00, 8'd17, 0, 0);

        // R8: saturation
        for (int i = 0; i < 240; i++) begin
            attempt(8'h01, 1'b0, 8'h00);
        end
        expect_snap("R8 saturated", 0, 0, 0, 8'h00, 8'd255, 0, 0);

        @(negedge clk);
        wait (sb_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule